// File: doc/BRIEF.md
# Ready-Edge Interrupt Controller

This unit sits beside a raw NAND flash port and turns the device's ready/busy pin into an interrupt request. The pin is active low: it is low while the flash is busy and high once it is ready. When the pin goes from busy to ready, the unit latches a request bit. The host can then sleep through a long erase or program operation instead of polling the pin.

The host sees two byte-wide registers. The status register holds the request in bit 0. Bits 1 to 3 are reserved source slots. Each status bit is cleared by writing a one to it. The mask register holds a per-source enable for each low bit and a global enable in bit 7. The interrupt output is a level that stays high until the host clears the request or masks it.

Before a long operation, the host clears the status with 0x0F and then writes 0x81 to the mask. After servicing the request, it writes 0x00 to the mask. Timeouts are handled by the host and are not part of this unit.

Top module: `rdyIrqTop`

## Requirements
- R1: While reset is asserted and right after it, status reads 0x00, mask reads 0x00 and irq is low.
- R2: A low-to-high change of busyN, sampled at clock edge k, sets status bit 0 at edge k+2. The bit therefore reads 1 after the third rising edge that follows the input change, and still reads 0 after the second.
- R3: A high-to-low change of busyN, a steady busyN at either level, and the release of reset with busyN high all leave the status register unchanged.
- R4: A write to address 0 clears every status bit whose data bit is one and leaves the bits written with zero unchanged. Status bits 3:1 always read 0.
- R5: When the mask holds 0x81, or 0x8F, irq equals status bit 0. irq follows a change of status or mask after the same clock edge that updates the register, with no added cycle.
- R6: With the mask at 0x00, irq stays low even while status bit 0 is set.
- R7: irq needs both mask bit 7 and mask bit 0. A mask of 0x01 or of 0x80 keeps irq low while status bit 0 is set.
- R8: If a ready edge sets status bit 0 in the same cycle as a write that clears it, the bit ends up set.
- R9: A write to address 1 stores mask bits 7 and 3:0. Mask bits 6:4 read 0, so writing 0xFF reads back 0x8F.
- R10: Status bit 0 stays set until a clear write. After it is cleared, it is set again only by a new busy-to-ready transition, not by busyN remaining high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busyN | input | 1 | Flash ready/busy pin, low while busy, asynchronous to clk |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 1 | Write address: 0 status (write one to clear), 1 mask |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read address: 0 status, 1 mask |
| rdData | output | 8 | Combinational read data for rdAddr |
| irq | output | 1 | Level interrupt request |

## Verification
A lost or stuck synchronizer flop appears as a request that lands one cycle early or late against the fixed three-edge latency. That latency is checked on both sides, so the error shows up in the very cycle it occurs. A wrong edge detector shows up as a status bit that sets on the busy edge, or sets again after a clear while the pin stays high. Both are visible on the status read within three cycles. A wrong priority between set and clear, or a broken mask gate, shows up directly on irq and on the read data after the single edge that updates the register.

// File: rtl/rdyIrqPkg.sv
package rdyIrqPkg;
  // number of status/enable source slots; slot 0 is the ready request
  localparam int SRC_W = 4;
  localparam int READY_SRC = 0;

  // register addresses
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [SRC_W-1:0] setBits;   // sources raising a request this cycle
    logic [SRC_W-1:0] clrBits;   // write-one-to-clear pattern this cycle
    logic             maskWe;    // load the mask register
  } ctlStrobeT;
endpackage

// File: rtl/rdyIrqCtl.sv
module rdyIrqCtl
  import rdyIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busyN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [SRC_W-1:0] wrLow,
  output ctlStrobeT        strb
);
  // synchronizer chain, reset to the ready level so that leaving reset
  // with the pin high raises no request
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   riseDet;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= busyN;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign riseDet = syncQ[SYNC_STAGES-1] & ~prevQ;

  always_comb begin
    strb = '0;
    strb.setBits[READY_SRC] = riseDet;
    if (wrEn && wrAddr == ADDR_STATUS) strb.clrBits = wrLow;
    strb.maskWe = wrEn && (wrAddr == ADDR_MASK);
  end
endmodule

// File: rtl/rdyIrqDp.sv
module rdyIrqDp
  import rdyIrqPkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int GLOBAL_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  // bits that physically exist in the mask register
  localparam logic [DATA_W-1:0] MASK_KEEP =
    (DATA_W'(1) << GLOBAL_EN_BIT) | DATA_W'((1 << SRC_W) - 1);
  // only the ready source is implemented; the rest are reserved
  localparam logic [SRC_W-1:0] SRC_LIVE = SRC_W'(1) << READY_SRC;

  logic [SRC_W-1:0] srcQ;
  logic [SRC_W-1:0] srcNext;

  // set wins over clear in the same cycle
  assign srcNext = ((srcQ & ~strb.clrBits) | strb.setBits) & SRC_LIVE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= '0;
    else       srcQ <= srcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWe) maskQ <= wrData & MASK_KEEP;
  end

  assign statusQ = DATA_W'(srcQ);
  assign irq     = maskQ[GLOBAL_EN_BIT] & (|(srcQ & maskQ[SRC_W-1:0]));
  assign rdData  = (rdAddr == ADDR_MASK) ? maskQ : statusQ;
endmodule

// File: rtl/rdyIrqTop.sv
module rdyIrqTop
  import rdyIrqPkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int GLOBAL_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ctlStrobeT         strb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;

  rdyIrqCtl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .busyN  (busyN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrLow  (wrData[SRC_W-1:0]),
    .strb   (strb)
  );

  rdyIrqDp #(.DATA_W(DATA_W), .GLOBAL_EN_BIT(GLOBAL_EN_BIT)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .rdData  (rdData),
    .irq     (irq)
  );
endmodule

// File: rtl/rdyIrqChk.sv
// Properties for rdyIrqTop; latency terms assume the default two-stage synchronizer.
module rdyIrqChk #(
  parameter int DATA_W        = 8,
  parameter int GLOBAL_EN_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busyN,
  input logic              wrEn,
  input logic              wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] maskQ,
  input logic              irq
);
  localparam logic [DATA_W-1:0] KEEP =
    (DATA_W'(1) << GLOBAL_EN_BIT) | DATA_W'(15);

  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R2 / R3: a new request only follows a busy-to-ready change three edges back
  assert_set_needs_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd5 && $rose(statusQ[0])) |-> ($past(busyN, 3) && !$past(busyN, 4)));

  // R4: the request only drops after a write of one to it
  assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusQ[0]) |-> $past(wrEn && !wrAddr && wrData[0]));

  // R10: held until cleared
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[0] && !(wrEn && !wrAddr && wrData[0])) |=> statusQ[0]);

  // R7: no request without the global enable
  assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[GLOBAL_EN_BIT] |-> !irq);

  // R9: mask load keeps only the implemented bits
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> (maskQ == ($past(wrData) & KEEP)));
endmodule

bind rdyIrqTop rdyIrqChk #(.DATA_W(DATA_W), .GLOBAL_EN_BIT(GLOBAL_EN_BIT)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busyN   (busyN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .irq     (irq)
);

// File: tb/test_rdyIrqTop.sv
module test_rdyIrqTop;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 27;

  // row: [31:28] req, [27] busyN, [26:25] op (0 idle, 1 status write, 2 mask write),
  //      [24:17] data, [16] irq, [15:8] status, [7:0] mask
  localparam logic [31:0] VEC [NROWS] = '{
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h00},  // R3 falling edge
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h00},  // R3
    {4'd4, 1'b0, 2'd1, 8'h0F, 1'b0, 8'h00, 8'h00},  // R4 clear all
    {4'd5, 1'b0, 2'd2, 8'h81, 1'b0, 8'h00, 8'h81},  // R5 enable
    {4'd2, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h81},  // R2 rise, edge 1
    {4'd2, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h81},  // R2 edge 2
    {4'd2, 1'b1, 2'd0, 8'h00, 1'b1, 8'h01, 8'h81},  // R2 edge 3 sets
    {4'd10,1'b1, 2'd0, 8'h00, 1'b1, 8'h01, 8'h81},  // R10 hold
    {4'd4, 1'b1, 2'd1, 8'h0E, 1'b1, 8'h01, 8'h81},  // R4 zeros leave bit
    {4'd6, 1'b1, 2'd2, 8'h00, 1'b0, 8'h01, 8'h00},  // R6 mask off
    {4'd7, 1'b1, 2'd2, 8'h01, 1'b0, 8'h01, 8'h01},  // R7 no global
    {4'd7, 1'b1, 2'd2, 8'h80, 1'b0, 8'h01, 8'h80},  // R7 no source
    {4'd9, 1'b1, 2'd2, 8'hFF, 1'b1, 8'h01, 8'h8F},  // R9 readback
    {4'd4, 1'b1, 2'd1, 8'h0F, 1'b0, 8'h00, 8'h8F},  // R4 clear
    {4'd10,1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R10 no re-set
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R3 falling
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R3
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R3
    {4'd8, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R8 rise
    {4'd8, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R8
    {4'd8, 1'b1, 2'd1, 8'h01, 1'b1, 8'h01, 8'h8F},  // R8 set beats clear
    {4'd4, 1'b1, 2'd1, 8'h01, 1'b0, 8'h00, 8'h8F},  // R4 clear
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R3
    {4'd2, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R2 short ready pulse
    {4'd2, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h8F},  // R2
    {4'd2, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 8'h8F},  // R2 latched
    {4'd3, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 8'h8F}   // R3 falling keeps it
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busyN = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdyIrqTop i_rdyIrqTop (
    .clk(clk), .rstN(rstN), .busyN(busyN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic expIrq, input logic [7:0] expStat, input logic [7:0] expMask);
    rdAddr = 1'b0; #1;
    check(req, "status", rdData, expStat);
    rdAddr = 1'b1; #1;
    check(req, "mask", rdData, expMask);
    check(req, "irq", {7'd0, irq}, {7'd0, expIrq});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkAll(1, 1'b0, 8'h00, 8'h00);
    rstN = 1'b1;
    // R3: leaving reset with the pin ready raises nothing
    repeat (4) @(negedge clk);
    checkAll(3, 1'b0, 8'h00, 8'h00);
    busyN = 1'b0;
    repeat (2) @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      logic [31:0] row;
      row    = VEC[r];
      busyN  = row[27];
      wrEn   = (row[26:25] != 2'd0);
      wrAddr = (row[26:25] == 2'd2);
      wrData = row[24:17];
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0;
      checkAll(int'(row[31:28]), row[16], row[15:8], row[7:0]);
    end

    // R1: reset in the middle of a pending request
    rstN = 1'b0;
    #1;
    checkAll(1, 1'b0, 8'h00, 8'h00);
    busyN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkAll(3, 1'b0, 8'h00, 8'h00);

    // R5: irq follows the mask on the write edge itself
    wrEn = 1'b1; wrAddr = 1'b1; wrData = 8'h81;
    busyN = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    busyN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll(5, 1'b1, 8'h01, 8'h81);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule